// File: doc/BRIEF.md
# External Trigger Edge Counter

This block is an up-counter that takes its count events from a conditioned external trigger pin or from the internal clock. The pin is first made active-high by an optional inversion. It is then brought into the internal clock domain by a two-stage synchronizer. A prescaler passes one of every 1, 2, 4 or 8 active edges, and a digital glitch filter requires a new level to persist before it is accepted. A rising-edge detector on the filtered level produces a single-cycle count enable.

When the external-clock enable is clear, the counter advances on every internal clock cycle instead. In both modes nothing counts unless the counter enable is set. The counter runs from zero up to a programmable reload value. On the next count event after that value it returns to zero and raises an overflow pulse for one cycle.

The block has no data stream, so every pin is a plain level. The configuration inputs behave like register fields that software sets up while the block is idle or held in reset.

Top module: `ext_trig_counter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `count` is 0 and `overflow` is 0.
- R2: When `cnt_en` is 0 on a clock edge, `count` keeps its value across that edge, in either mode.
- R3: With `ext_clk_en` = 0 and `cnt_en` = 1, `count` increases by one on every clock edge until it reaches `reload_val`.
- R4: With `ext_clk_en` = 1, `trig_inv` = 0, `psc_sel` = 00 and `filt_len` = 0, each rising edge on `trig_in` adds one to `count`. The increment appears on the fourth clock edge, counting the edge that first samples the new high level as the first.
- R5: With `trig_inv` = 1, the pin is inverted before any other stage, so falling edges of `trig_in` are counted and rising edges are not.
- R6: `psc_sel` = 00, 01, 10 and 11 give one increment per 1, 2, 4 and 8 active edges. After reset the first increment comes on the 2^`psc_sel`-th edge.
- R7: For `filt_len` = N, the filtered level follows a new prescaled level only once that level has been present for N+1 consecutive clock edges. A pulse shorter than N+1 cycles is not counted. N = 0 passes the level through after one register.
- R8: A count event that finds `count` equal to `reload_val` sets `count` to 0 and raises `overflow` for exactly that one following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | External trigger pin, asynchronous |
| trig_inv | input | 1 | 1 inverts the pin so that falling edges count |
| psc_sel | input | 2 | Prescale code: divide active edges by 2^code |
| filt_len | input | 4 | Glitch filter length N; 0 means no filtering |
| ext_clk_en | input | 1 | 1 selects the trigger path as the count source, 0 selects the internal clock |
| cnt_en | input | 1 | Counter enable |
| reload_val | input | 16 | Top value of the count before wrapping |
| count | output | 16 | Current counter value |
| overflow | output | 1 | One-cycle pulse when the counter wraps to zero |

## Verification
The assertions take the configuration inputs (`trig_inv`, `psc_sel`, `filt_len`, `ext_clk_en`) as steady while counting is under way. They also take each high and low phase of the trigger pin to last at least two clock cycles, so that the synchronizer never misses a level. The stimulus changes configuration only while reset is asserted or while the pin is idle. The narrowest pin phases it drives are the three-cycle glitches aimed at the filter, and every other phase is four cycles or longer. A behavioural model in the bench follows the same pin samples and is compared against `count` and `overflow` on every cycle.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int unsigned ETC_CNT_W   = 16;
  localparam int unsigned ETC_PSC_W   = 2;
  localparam int unsigned ETC_FILT_W  = 4;
  localparam int unsigned ETC_SYNC_N  = 2;

  // Count source selected for the counter core
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_TRIGGER  = 1'b1
  } etc_src_e;
endpackage

// File: rtl/etc_sync_psc.sv
module etc_sync_psc #(
  parameter int unsigned PSC_W  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             inv,
  input  logic [PSC_W-1:0] psc_sel,
  output logic             lvl
);
  // Largest code selects 2^(2^PSC_W - 1); that many counter bits suffice.
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [SYNC_N-1:0] sync_q;
  logic              sync_out;
  logic              sync_prev;
  logic              sync_rise;
  logic [DIV_W-1:0]  edge_cnt;
  logic [DIV_W-1:0]  div_mask;
  logic              div_lvl;

  assign sync_out  = sync_q[SYNC_N-1];
  assign sync_rise = sync_out & ~sync_prev;

  always_comb begin
    div_mask = '0;
    for (int i = 0; i < int'(DIV_W); i++) begin
      if (i < int'(psc_sel)) div_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      sync_prev <= 1'b0;
      edge_cnt  <= '0;
      div_lvl   <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_N-2:0], pin ^ inv};
      sync_prev <= sync_out;
      if (sync_rise) begin
        if ((edge_cnt & div_mask) == div_mask) begin
          edge_cnt <= '0;
          div_lvl  <= 1'b1;
        end else begin
          edge_cnt <= edge_cnt + 1'b1;
          div_lvl  <= 1'b0;
        end
      end
    end
  end

  generate
    if (PSC_W == 0) begin : g_nodiv
      assign lvl = sync_out;
    end else begin : g_div
      assign lvl = (psc_sel == '0) ? sync_out : div_lvl;
    end
  endgenerate
endmodule

// File: rtl/etc_glitch_filter.sv
module etc_glitch_filter #(
  parameter int unsigned FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] filt_len,
  output logic              dout
);
  logic [FILT_W-1:0] down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      down_q <= '0;
      dout   <= 1'b0;
    end else if (din == dout) begin
      down_q <= filt_len;
    end else if (down_q == '0) begin
      dout   <= din;
      down_q <= filt_len;
    end else begin
      down_q <= down_q - 1'b1;
    end
  end
endmodule

// File: rtl/etc_count_core.sv
module etc_count_core
  import etc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_lvl,
  input  logic             ext_clk_en,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             edge_pulse
);
  logic     filt_prev;
  logic     tick;
  etc_src_e src;

  assign src        = etc_src_e'(ext_clk_en);
  assign edge_pulse = filt_lvl & ~filt_prev;
  assign tick       = (src == SRC_TRIGGER) ? edge_pulse : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_prev <= 1'b0;
      count     <= '0;
      overflow  <= 1'b0;
    end else begin
      filt_prev <= filt_lvl;
      overflow  <= 1'b0;
      if (cnt_en && tick) begin
        if (count == reload_val) begin
          count    <= '0;
          overflow <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ext_trig_counter.sv
module ext_trig_counter
  import etc_pkg::*;
#(
  parameter int unsigned CNT_W  = ETC_CNT_W,
  parameter int unsigned PSC_W  = ETC_PSC_W,
  parameter int unsigned FILT_W = ETC_FILT_W,
  parameter int unsigned SYNC_N = ETC_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              trig_inv,
  input  logic [PSC_W-1:0]  psc_sel,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              ext_clk_en,
  input  logic              cnt_en,
  input  logic [CNT_W-1:0]  reload_val,
  output logic [CNT_W-1:0]  count,
  output logic              overflow
);
  logic psc_lvl;
  logic filt_lvl;
  logic edge_pulse;

  etc_sync_psc #(.PSC_W(PSC_W), .SYNC_N(SYNC_N)) u_sync_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (trig_in),
    .inv     (trig_inv),
    .psc_sel (psc_sel),
    .lvl     (psc_lvl)
  );

  etc_glitch_filter #(.FILT_W(FILT_W)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (psc_lvl),
    .filt_len (filt_len),
    .dout     (filt_lvl)
  );

  etc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt_lvl   (filt_lvl),
    .ext_clk_en (ext_clk_en),
    .cnt_en     (cnt_en),
    .reload_val (reload_val),
    .count      (count),
    .overflow   (overflow),
    .edge_pulse (edge_pulse)
  );
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_clk_en,
  input logic             cnt_en,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] count,
  input logic             overflow,
  input logic             edge_pulse
);
  assert_hold_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  assert_internal_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !ext_clk_en && count != reload_val) |=> (count == $past(count) + 1'b1));

  assert_ext_waits_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && ext_clk_en && !edge_pulse) |=> $stable(count));

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (count == '0));

  assert_wrap_from_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($past(count) == $past(reload_val)));
endmodule

bind ext_trig_counter etc_checker #(.CNT_W(CNT_W)) u_etc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_clk_en (ext_clk_en),
  .cnt_en     (cnt_en),
  .reload_val (reload_val),
  .count      (count),
  .overflow   (overflow),
  .edge_pulse (edge_pulse)
);

// File: tb/sim_ext_trig_counter.sv
`timescale 1ns/1ps
module sim_ext_trig_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        trig_inv = 1'b0;
  logic [1:0]  psc_sel = 2'b00;
  logic [3:0]  filt_len = 4'd0;
  logic        ext_clk_en = 1'b0;
  logic        cnt_en = 1'b0;
  logic [15:0] reload_val = 16'hFFFF;
  logic [15:0] count;
  logic        overflow;

  int n_tests = 0;
  int n_fail  = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_trig_counter u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_inv(trig_inv),
    .psc_sel(psc_sel), .filt_len(filt_len), .ext_clk_en(ext_clk_en),
    .cnt_en(cnt_en), .reload_val(reload_val), .count(count), .overflow(overflow)
  );

  // Behavioural reference: history of active pin samples, edge tallies
  int m_hist[$];
  int m_edges, m_div, m_filt, m_filt_old, m_run, m_cnt, m_ovf;

  always @(posedge clk) begin
    int syn, syn_old, src, tick;
    if (!rst_n) begin
      m_hist = {0, 0, 0};
      m_edges = 0; m_div = 0; m_filt = 0; m_filt_old = 0;
      m_run = 0; m_cnt = 0; m_ovf = 0;
    end else begin
      tick = ext_clk_en ? (m_filt == 1 && m_filt_old == 0) : 1;
      m_ovf = 0;
      if (cnt_en && tick) begin
        if (m_cnt == int'(reload_val)) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
      end
      m_filt_old = m_filt;
      syn = m_hist[1]; syn_old = m_hist[2];
      src = (psc_sel == 2'b00) ? syn : m_div;
      if (src == m_filt) m_run = 0;
      else begin
        m_run = m_run + 1;
        if (m_run > int'(filt_len)) begin m_filt = src; m_run = 0; end
      end
      if (syn == 1 && syn_old == 0) begin
        m_edges = m_edges + 1;
        m_div = ((m_edges % (1 << psc_sel)) == 0) ? 1 : 0;
      end
      m_hist.push_front(int'(trig_in ^ trig_inv));
      void'(m_hist.pop_back());
    end
    #5;
    n_tests++;
    if (int'(count) != m_cnt || int'(overflow) != m_ovf) begin
      n_fail++;
      $display("FAIL %s model: count=%0d ovf=%0d expected count=%0d ovf=%0d",
               phase, count, overflow, m_cnt, m_ovf);
    end
  end

  task automatic expect_val(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit inv, input bit [1:0] psc, input bit [3:0] flt,
                          input bit ext, input bit [15:0] top);
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0;
    trig_inv = inv; trig_in = inv; psc_sel = psc; filt_len = flt;
    ext_clk_en = ext; reload_val = top;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drives the active level (before inversion) high then low
  task automatic pulse(input int hi, input int lo);
    @(negedge clk); trig_in = ~trig_inv;
    repeat (hi - 1) @(negedge clk);
    @(negedge clk); trig_in = trig_inv;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    phase = "R1";
    do_reset(0, 2'b00, 4'd0, 0, 16'hFFFF);
    @(posedge clk); #5;
    expect_val("R1 count", int'(count), 0);
    expect_val("R1 overflow", int'(overflow), 0);

    // R3 internal clock counting
    phase = "R3";
    @(negedge clk); cnt_en = 1'b1;
    repeat (10) @(posedge clk); #5;
    expect_val("R3 count after 10 cycles", int'(count), 10);

    // R2 hold while disabled
    phase = "R2";
    @(negedge clk); cnt_en = 1'b0;
    repeat (6) @(posedge clk); #5;
    expect_val("R2 count held", int'(count), 10);

    // R8 wrap in internal mode
    phase = "R8";
    do_reset(0, 2'b00, 4'd0, 0, 16'd5);
    @(negedge clk); cnt_en = 1'b1;
    repeat (6) @(posedge clk); #5;
    expect_val("R8 count wrapped", int'(count), 0);
    expect_val("R8 overflow high", int'(overflow), 1);
    @(posedge clk); #5;
    expect_val("R8 overflow one cycle", int'(overflow), 0);
    expect_val("R8 count after wrap", int'(count), 1);

    // R4 rising edges, latency
    phase = "R4";
    do_reset(0, 2'b00, 4'd0, 1, 16'hFFFF);
    @(negedge clk); cnt_en = 1'b1;
    idle(3);
    trig_in = 1'b1;
    repeat (3) @(posedge clk); #5;
    expect_val("R4 no change at third edge", int'(count), 0);
    @(posedge clk); #5;
    expect_val("R4 increment at fourth edge", int'(count), 1);
    @(negedge clk); trig_in = 1'b0;
    idle(4);
    for (int i = 0; i < 5; i++) pulse(4, 4);
    idle(8);
    expect_val("R4 six rising edges", int'(count), 6);

    // R5 falling edges with inversion
    phase = "R5";
    do_reset(1, 2'b00, 4'd0, 1, 16'hFFFF);
    @(negedge clk); cnt_en = 1'b1;
    idle(4);
    for (int i = 0; i < 7; i++) pulse(5, 4);
    idle(8);
    expect_val("R5 seven falling edges", int'(count), 7);

    // R6 prescaler codes
    for (int c = 1; c < 4; c++) begin
      phase = "R6";
      do_reset(0, 2'(c), 4'd0, 1, 16'hFFFF);
      @(negedge clk); cnt_en = 1'b1;
      idle(4);
      for (int i = 0; i < 17; i++) pulse(4, 4);
      idle(10);
      expect_val($sformatf("R6 code %0d count", c), int'(count), 17 / (1 << c));
    end

    // R7 glitch filter
    phase = "R7";
    do_reset(0, 2'b00, 4'd5, 1, 16'hFFFF);
    @(negedge clk); cnt_en = 1'b1;
    idle(4);
    for (int i = 0; i < 4; i++) pulse(3, 6);
    idle(10);
    expect_val("R7 short pulses ignored", int'(count), 0);
    for (int i = 0; i < 3; i++) pulse(10, 10);
    idle(12);
    expect_val("R7 long pulses counted", int'(count), 3);

    // R8 wrap in trigger mode
    phase = "R8";
    do_reset(0, 2'b00, 4'd0, 1, 16'd2);
    @(negedge clk); cnt_en = 1'b1;
    idle(4);
    for (int i = 0; i < 4; i++) pulse(4, 4);
    idle(8);
    expect_val("R8 trigger-mode wrap", int'(count), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule